// File: doc/BRIEF.md
# Paired Tick-Driven Timer/Counter

This block holds two independent up-counting timers behind a small byte-wide register bus. Each timer is a pair of readable and writable bytes, a low byte and a high byte. It advances by one on every clock in which the shared tick-enable input is high and its own run bit is set. A shared mode register gives each timer a nibble, and the lower two bits of that nibble choose how the two bytes count. The choices are a 13-bit count whose low byte acts as a 5-bit prescaler, a plain 16-bit count, and an 8-bit count whose low byte reloads from the high byte when it wraps. The fourth mode value halts the timer.

When a timer wraps, it raises a sticky overflow flag. The flag is visible in the control register and on a dedicated output pin. The flag is cleared either by software through the control register or by a one-cycle acknowledge pulse from an interrupt controller. Register writes land on the next clock. Read data is registered and appears one clock after the address is presented.

Top module: `tick_timer_pair`

## Requirements
- R1: After a synchronous active-high reset, every register reads zero, `rd_data` is zero and both `ovf_flag` bits are low.
- R2: Register map on `bus_addr`: 0 control, 1 mode, 2 timer 0 low, 3 timer 0 high, 4 timer 1 low, 5 timer 1 high; 6 and 7 read zero. A write with `bus_wr` high takes effect on the next clock. `rd_data` shows the register addressed in the previous cycle.
- R3: Control register bit 7 is the timer 1 flag, bit 6 timer 1 run, bit 5 the timer 0 flag, bit 4 timer 0 run. Bits 3:0 are plain storage. In the mode register, bits 1:0 are the timer 0 mode and bits 5:4 the timer 1 mode, with codes 0=13-bit, 1=16-bit, 2=8-bit reload, 3=halt. Its other bits are stored and read back.
- R4: A timer changes only in a cycle where its run bit is 1 and `tick` is 1, apart from register writes.
- R5: In 16-bit mode, {high,low} increments by one. Going from 0xFFFF to 0x0000 sets the flag.
- R6: In 13-bit mode, only low bits 4:0 count. Low bits 7:5 are untouched. When bits 4:0 pass 31 they return to 0 and the high byte increments. If the high byte was 0xFF, it becomes 0 and the flag is set.
- R7: In 8-bit reload mode, the low byte increments. When it is 0xFF, it takes the high byte value instead, the high byte holds, and the flag is set.
- R8: Mode code 3 leaves the timer unchanged even with run and tick high.
- R9: A flag stays set until a control write stores 0 in it or `ovf_ack` for that timer is high. An overflow in the same cycle as either clear leaves the flag set. `ovf_flag` mirrors the flag bits.
- R10: A write to either byte of a timer suppresses that timer's count in that cycle. The written byte takes the bus value and the other byte holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable pulse shared by both timers |
| ovf_ack | input | 2 | Per-timer acknowledge pulse clearing the flag |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| rd_data | output | DW | Registered read data |
| ovf_flag | output | 2 | Overflow flags, bit i for timer i |

## Verification
Two pairs of events can land in one cycle. A timer wrap can coincide with a clearing acknowledge, and a software byte write can coincide with a counting step. The bench holds `ovf_ack` high across a stretch of 8-bit reload wraps, so that acknowledge and wrap meet on the wrap cycles and the flag must survive only there. It also writes a running timer's low byte on consecutive ticking cycles. A behavioural model steps alongside the design every clock, and the registered read data and both flag pins are compared against it at every falling edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_PRESC13 = 2'd0,
    MD_FULL16  = 2'd1,
    MD_RELOAD8 = 2'd2,
    MD_HALT    = 2'd3
  } tmr_mode_e;

  localparam int REG_CTL  = 0;
  localparam int REG_MODE = 1;
  localparam int REG_TLO0 = 2;  // timer i low byte at REG_TLO0 + 2*i, high byte one above
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic          tick_i,
  input  tmr_mode_e     mode_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] hi_o,
  output logic          ovf_o
);
  localparam logic [DW-1:0] BMAX = {DW{1'b1}};
  localparam logic [PW-1:0] PMAX = {PW{1'b1}};

  logic [DW-1:0] lo_q, hi_q, lo_n, hi_n;
  logic          adv;
  logic [2*DW:0] wide;

  assign adv  = run_i && tick_i && (mode_i != MD_HALT) && !wr_lo_i && !wr_hi_i;
  assign wide = {1'b0, hi_q, lo_q} + {{(2*DW){1'b0}}, 1'b1};

  always_comb begin
    lo_n  = lo_q;
    hi_n  = hi_q;
    ovf_o = 1'b0;
    if (adv) begin
      case (mode_i)
        MD_PRESC13: begin
          if (lo_q[PW-1:0] == PMAX) begin
            lo_n  = {lo_q[DW-1:PW], {PW{1'b0}}};
            hi_n  = hi_q + 1'b1;
            ovf_o = (hi_q == BMAX);
          end else begin
            lo_n = {lo_q[DW-1:PW], lo_q[PW-1:0] + 1'b1};
          end
        end
        MD_FULL16: begin
          lo_n  = wide[DW-1:0];
          hi_n  = wide[2*DW-1:DW];
          ovf_o = wide[2*DW];
        end
        MD_RELOAD8: begin
          if (lo_q == BMAX) begin
            lo_n  = hi_q;
            ovf_o = 1'b1;
          end else begin
            lo_n = lo_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (wr_lo_i) lo_n = wdata_i;
    if (wr_hi_i) hi_n = wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !wr_lo_i && !wr_hi_i) |=> ($stable(lo_o) && $stable(hi_o)));

  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MD_HALT && !wr_lo_i && !wr_hi_i) |=> ($stable(lo_o) && $stable(hi_o)));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_lo_i && !wr_hi_i) |=> (lo_o == $past(wdata_i) && hi_o == $past(hi_o)));

  assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
    (run_i && tick_i && mode_i == MD_RELOAD8 && lo_o == BMAX && !wr_lo_i && !wr_hi_i)
      |=> (lo_o == $past(hi_o) && $stable(hi_o)));
endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux
  import tmr_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter int NT = 2
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    ctl_i,
  input  logic [DW-1:0]    mode_i,
  input  logic [NT*DW-1:0] lo_i,
  input  logic [NT*DW-1:0] hi_i,
  output logic [DW-1:0]    data_o
);
  always_comb begin
    data_o = '0;
    if (addr_i == AW'(REG_CTL))  data_o = ctl_i;
    if (addr_i == AW'(REG_MODE)) data_o = mode_i;
    for (int i = 0; i < NT; i++) begin
      if (addr_i == AW'(REG_TLO0 + 2*i))     data_o = lo_i[i*DW +: DW];
      if (addr_i == AW'(REG_TLO0 + 2*i + 1)) data_o = hi_i[i*DW +: DW];
    end
  end
endmodule

// File: rtl/tick_timer_pair.sv
module tick_timer_pair
  import tmr_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [1:0]    ovf_ack,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] rd_data,
  output logic [1:0]    ovf_flag
);
  localparam int NT   = 2;
  localparam int AUXW = DW - 2*NT;
  localparam int MNW  = DW / NT;

  logic [1:0]       run_q, flag_q, ovf;
  logic [AUXW-1:0]  aux_q;
  logic [DW-1:0]    mode_q, ctl_byte, rd_n;
  logic [NT*DW-1:0] lo_all, hi_all;
  logic             ctl_wr, mode_wr;

  assign ctl_wr  = bus_wr && (bus_addr == AW'(REG_CTL));
  assign mode_wr = bus_wr && (bus_addr == AW'(REG_MODE));

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    tmr_counter #(.DW(DW), .PW(PW)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .run_i   (run_q[i]),
      .tick_i  (tick),
      .mode_i  (tmr_mode_e'(mode_q[i*MNW +: 2])),
      .wr_lo_i (bus_wr && (bus_addr == AW'(REG_TLO0 + 2*i))),
      .wr_hi_i (bus_wr && (bus_addr == AW'(REG_TLO0 + 2*i + 1))),
      .wdata_i (bus_wdata),
      .lo_o    (lo_all[i*DW +: DW]),
      .hi_o    (hi_all[i*DW +: DW]),
      .ovf_o   (ovf[i])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        run_q[i]  <= 1'b0;
        flag_q[i] <= 1'b0;
      end else begin
        if (ctl_wr) run_q[i] <= bus_wdata[AUXW + 2*i];
        flag_q[i] <= ovf[i] | (ctl_wr ? bus_wdata[AUXW + 2*i + 1]
                                      : (flag_q[i] & ~ovf_ack[i]));
      end
    end

    assert_flag_set_R9: assert property (@(posedge clk) disable iff (rst)
      ovf[i] |=> ovf_flag[i]);
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      (ovf_flag[i] && !ovf_ack[i] && !ctl_wr) |=> ovf_flag[i]);
    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
      (ovf_ack[i] && !ovf[i] && !ctl_wr) |=> !ovf_flag[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aux_q  <= '0;
      mode_q <= '0;
    end else begin
      if (ctl_wr)  aux_q  <= bus_wdata[AUXW-1:0];
      if (mode_wr) mode_q <= bus_wdata;
    end
  end

  assign ctl_byte = {flag_q[1], run_q[1], flag_q[0], run_q[0], aux_q};

  tmr_read_mux #(.DW(DW), .AW(AW), .NT(NT)) u_rd (
    .addr_i (bus_addr),
    .ctl_i  (ctl_byte),
    .mode_i (mode_q),
    .lo_i   (lo_all),
    .hi_i   (hi_all),
    .data_o (rd_n)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_n;
  end

  assign ovf_flag = flag_q;

  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (rd_data == '0 && ovf_flag == 2'b00));
  assert_regwrite_R2: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (mode_q == $past(bus_wdata)));
endmodule

// File: tb/tick_timer_pair_bench.sv
`timescale 1ns/1ps
module tick_timer_pair_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] ovf_ack = 2'b00;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] rd_data;
  logic [1:0] ovf_flag;

  int total = 0;
  int bad = 0;
  string phase = "R1";

  int m_lo[2], m_hi[2], m_run[2], m_flag[2];
  int m_aux, m_mode, m_rd;

  always #4 clk = ~clk;

  tick_timer_pair u_tick_timer_pair (
    .clk(clk), .rst(rst), .tick(tick), .ovf_ack(ovf_ack),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .ovf_flag(ovf_flag)
  );

  function automatic int mread(int a);
    case (a)
      0: return (m_flag[1] << 7) | (m_run[1] << 6) | (m_flag[0] << 5) | (m_run[0] << 4) | m_aux;
      1: return m_mode;
      2: return m_lo[0];
      3: return m_hi[0];
      4: return m_lo[1];
      5: return m_hi[1];
      default: return 0;
    endcase
  endfunction

  // reference model: advances once per rising edge
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_lo[i] = 0; m_hi[i] = 0; m_run[i] = 0; m_flag[i] = 0;
      end
      m_aux = 0; m_mode = 0; m_rd = 0;
    end else begin
      int a, d, md, nlo, nhi, ov, nrun[2];
      a = int'(bus_addr);
      d = int'(bus_wdata);
      m_rd = mread(a);
      for (int i = 0; i < 2; i++) begin
        md = (m_mode >> (4 * i)) & 3;
        nlo = m_lo[i]; nhi = m_hi[i]; ov = 0;
        if (bus_wr && (a == 2 + 2 * i || a == 3 + 2 * i)) begin
          if (a == 2 + 2 * i) nlo = d; else nhi = d;
        end else if (m_run[i] == 1 && tick && md != 3) begin
          if (md == 1) begin
            int v;
            v = m_hi[i] * 256 + m_lo[i] + 1;
            if (v == 65536) begin v = 0; ov = 1; end
            nlo = v % 256; nhi = v / 256;
          end else if (md == 0) begin
            if ((m_lo[i] & 31) == 31) begin
              nlo = m_lo[i] & 224;
              if (m_hi[i] == 255) begin nhi = 0; ov = 1; end
              else nhi = m_hi[i] + 1;
            end else nlo = m_lo[i] + 1;
          end else begin
            if (m_lo[i] == 255) begin nlo = m_hi[i]; ov = 1; end
            else nlo = m_lo[i] + 1;
          end
        end
        m_lo[i] = nlo; m_hi[i] = nhi;
        nrun[i] = m_run[i];
        if (bus_wr && a == 0) begin
          nrun[i] = (d >> (4 + 2 * i)) & 1;
          m_flag[i] = (d >> (5 + 2 * i)) & 1;
        end else if (ovf_ack[i]) m_flag[i] = 0;
        if (ov) m_flag[i] = 1;
      end
      m_run[0] = nrun[0]; m_run[1] = nrun[1];
      if (bus_wr && a == 0) m_aux = d & 15;
      if (bus_wr && a == 1) m_mode = d;
    end
  end

  task automatic check(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    check("rd_data", int'(rd_data), m_rd);
    check("ovf_flag", int'(ovf_flag), m_flag[1] * 2 + m_flag[0]);
  endtask

  task automatic cycles(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic wr(int a, int d);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic sweep();
    for (int a = 0; a < 8; a++) begin
      bus_addr = 3'(a);
      cyc();
    end
    cyc();
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    phase = "R1";
    check("reset rd_data", int'(rd_data), 0);
    check("reset ovf_flag", int'(ovf_flag), 0);
    sweep();

    phase = "R3";
    wr(0, 8'h0A);
    wr(1, 8'hC3);
    sweep();

    phase = "R2";
    wr(2, 8'h12); wr(3, 8'h34); wr(4, 8'h56); wr(5, 8'h78);
    sweep();

    phase = "R4";
    wr(1, 8'h11);
    wr(2, 8'hF0); wr(3, 8'hFF);
    tick = 1'b1; bus_addr = 3'd2;
    cycles(5);
    wr(0, 8'h10);
    bus_addr = 3'd2;
    for (int k = 0; k < 10; k++) begin
      tick = k[0];
      cyc();
    end
    tick = 1'b0;
    cycles(3);

    phase = "R5";
    tick = 1'b1; bus_addr = 3'd3;
    cycles(12);
    bus_addr = 3'd2;
    cycles(6);
    bus_addr = 3'd0;
    cycles(4);

    phase = "R6";
    wr(1, 8'h01);
    wr(4, 8'hFA); wr(5, 8'hFF);
    wr(0, 8'h50);
    bus_addr = 3'd4;
    cycles(40);
    bus_addr = 3'd5;
    cycles(40);
    bus_addr = 3'd0;
    cycles(3);

    phase = "R7";
    wr(0, 8'h00);
    wr(1, 8'h02);
    wr(3, 8'hF8); wr(2, 8'hFC);
    wr(0, 8'h10);
    bus_addr = 3'd2;
    cycles(30);

    phase = "R9";
    wr(3, 8'hFE);
    bus_addr = 3'd0;
    ovf_ack = 2'b01;
    cycles(20);
    ovf_ack = 2'b00;
    cycles(4);
    wr(0, 8'h10);
    cycles(3);
    wr(0, 8'h30);
    cycles(2);
    ovf_ack = 2'b10;
    cycles(2);
    ovf_ack = 2'b00;

    phase = "R10";
    wr(2, 8'h40);
    wr(2, 8'h41);
    wr(2, 8'hF0);
    wr(3, 8'h22);
    bus_addr = 3'd2;
    cycles(4);
    bus_addr = 3'd3;
    cycles(2);

    phase = "R8";
    wr(1, 8'h33);
    wr(0, 8'h50);
    bus_addr = 3'd2;
    cycles(6);
    bus_addr = 3'd4;
    cycles(6);
    tick = 1'b0;
    sweep();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule